// File: doc/BRIEF.md
# Pixel-Bus to PCI Target Bridge

This block lets a host PCI initiator read a parallel image sensor directly. It acts as the only target on a dedicated 32-bit AD bus. Every transaction the initiator opens is claimed, and the address is never looked at. The block then completes one data beat for each sensor pixel. The sensor pixel clock, LineValid and the pixel word are carried into the PCI clock domain through one register pipeline, so all three stay aligned. A falling edge of the synchronised pixel clock arms TRDY#. A completed beat or a rising pixel clock releases it. The 10-bit pixel is placed zero-extended on the low AD bits.

The host reads one sensor line per burst. It opens a read and keeps IRDY# low. It deasserts FRAME# on the beat it wants to be the last. The transaction may be opened before the line starts. The target inserts wait states until LineValid is seen. The AD output enable is raised only while a line is valid, and only from the second data-phase cycle on. While it is low, external pull-ups make the bus read as all ones. DEVSEL# and TRDY# are driven high for one turnaround cycle after the final beat and then float.

Top module: `pix2pci_target`

## Requirements
- R1: While rst_ni is low, and after it rises with FRAME# high, devsel_oe_o, trdy_oe_o and ad_oe_o are 0, and devsel_no and trdy_no are 1.
- R2: When FRAME# is sampled low in the idle state, the clock edge that samples it drives devsel_oe_o=1 and devsel_no=0, whatever is on the bus. ad_oe_o is still 0 in the cycle that follows.
- R3: An open transaction with LineValid low keeps trdy_no=1 and ad_oe_o=0 while the pixel clock toggles. Beats start once LineValid rises.
- R4: With a two-stage synchroniser, trdy_no goes low at the third PCI clock edge after pclk_i falls. It stays high at the two edges before that.
- R5: At a 4:1 PCI-to-pixel clock ratio with IRDY# held low, trdy_no is low for exactly one PCI clock per pixel. The number of beats equals the number of valid pixels.
- R6: If IRDY# is high while TRDY# is asserted, TRDY# is held and the beat completes when IRDY# falls. If the synchronised pixel clock rises first, TRDY# is released and that pixel is not transferred.
- R7: At a 2:1 ratio with IRDY# held low, one beat completes per pixel. The beats carry the pixels in sensor order with none repeated.
- R8: Whenever TRDY# is asserted, ad_oe_o=1 and devsel_no=0. On each beat, ad_o[9:0] holds the pixel and ad_o[31:10] are 0.
- R9: After a beat with FRAME# high, the next cycle shows devsel_oe_o=1, devsel_no=1 and trdy_no=1. In the cycle after that, devsel_oe_o=0 and trdy_oe_o=0.
- R10: When LineValid falls inside a transaction, beats and the AD drive stop within one pixel. They resume with the next valid pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | PCI clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | FRAME# from initiator |
| irdy_ni | input | 1 | IRDY# from initiator |
| pclk_i | input | 1 | Sensor pixel clock (asynchronous) |
| line_valid_i | input | 1 | Sensor LineValid |
| pix_i | input | PIX_W (10) | Sensor pixel word |
| devsel_no | output | 1 | DEVSEL# value |
| devsel_oe_o | output | 1 | DEVSEL# drive enable |
| trdy_no | output | 1 | TRDY# value |
| trdy_oe_o | output | 1 | TRDY# drive enable |
| ad_o | output | AD_W (32) | AD bus value |
| ad_oe_o | output | 1 | AD bus drive enable |

## Verification
Some properties are checked on every cycle. A claim only follows a sampled FRAME#. TRDY# never rises without a preceding valid pixel-clock fall. LineValid low or a pixel-clock rise always releases TRDY#. TRDY# is never asserted without data on AD and a claimed DEVSEL#. The turnaround and float sequence after the final beat is also checked every cycle. Other behaviour only the bench scenarios can show: the exact edge count from pclk_i to TRDY#, the pixel order and count at both clock ratios, a held beat against a dropped pixel under initiator wait states, and gaps in LineValid before and inside a burst.

// File: rtl/pix2pci_pkg.sv
package pix2pci_pkg;
  typedef enum logic [1:0] {
    TGT_IDLE = 2'd0,
    TGT_DATA = 2'd1,
    TGT_TURN = 2'd2
  } tgt_state_e;
endpackage

// File: rtl/pix2pci_sync.sv
module pix2pci_sync #(
  parameter int STAGES = 2,
  parameter int W      = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pclk_i,
  input  logic         lv_i,
  input  logic [W-1:0] pix_i,
  output logic         fall_o,
  output logic         rise_o,
  output logic         lv_o,
  output logic [W-1:0] pix_o
);
  localparam int VW = W + 2;

  // pixel clock, line valid and data travel together so they stay aligned
  logic [STAGES-1:0][VW-1:0] stage_q;
  logic [VW-1:0]             last;
  logic                      pclk_s;
  logic                      pclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= {pclk_i, lv_i, pix_i};
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign last   = stage_q[STAGES-1];
  assign pclk_s = last[VW-1];
  assign lv_o   = last[W];
  assign pix_o  = last[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pclk_prev_q <= 1'b0;
    else         pclk_prev_q <= pclk_s;
  end

  assign fall_o = pclk_prev_q & ~pclk_s;
  assign rise_o = ~pclk_prev_q & pclk_s;
endmodule

// File: rtl/pix2pci_claim.sv
module pix2pci_claim
  import pix2pci_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_ni,
  input  logic irdy_ni,
  input  logic trdy_i,
  output logic accept_o,
  output logic devsel_no,
  output logic devsel_oe_o
);
  tgt_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TGT_IDLE: if (!frame_ni) state_d = TGT_DATA;
      TGT_DATA: if (trdy_i && !irdy_ni && frame_ni) state_d = TGT_TURN;
      TGT_TURN: state_d = TGT_IDLE;
      default:  state_d = TGT_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TGT_IDLE;
    else         state_q <= state_d;
  end

  // beats allowed only while staying in the data phase
  assign accept_o    = (state_q == TGT_DATA) && (state_d == TGT_DATA);
  assign devsel_oe_o = (state_q != TGT_IDLE);
  assign devsel_no   = (state_q != TGT_DATA);

  // R2: a claim only follows FRAME# sampled low
  a_r2_claim_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(devsel_oe_o) |-> $past(!frame_ni));
endmodule

// File: rtl/pix2pci_pacer.sv
module pix2pci_pacer #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         accept_i,
  input  logic         fall_i,
  input  logic         rise_i,
  input  logic         lv_i,
  input  logic [W-1:0] pix_i,
  input  logic         irdy_ni,
  output logic         trdy_o,
  output logic         ad_oe_o,
  output logic [W-1:0] pix_o
);
  logic         trdy_q, trdy_d;
  logic         ad_oe_q;
  logic [W-1:0] pix_q;

  always_comb begin
    trdy_d = trdy_q;
    if (!accept_i || !lv_i)            trdy_d = 1'b0;
    else if (fall_i)                   trdy_d = 1'b1;
    else if (rise_i || (trdy_q && !irdy_ni)) trdy_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trdy_q  <= 1'b0;
      ad_oe_q <= 1'b0;
      pix_q   <= '0;
    end else begin
      trdy_q  <= trdy_d;
      ad_oe_q <= accept_i && lv_i;
      if (accept_i && lv_i && fall_i) pix_q <= pix_i;
    end
  end

  assign trdy_o  = trdy_q;
  assign ad_oe_o = ad_oe_q;
  assign pix_o   = pix_q;

  a_r4_trdy_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trdy_q) |-> $past(fall_i && lv_i && accept_i));
  a_r3_no_trdy_without_lv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lv_i |=> !trdy_q);
  a_r6_rise_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> !trdy_q);
endmodule

// File: rtl/pix2pci_target.sv
module pix2pci_target #(
  parameter int PIX_W       = 10,
  parameter int AD_W        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ni,
  input  logic             irdy_ni,
  input  logic             pclk_i,
  input  logic             line_valid_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             devsel_no,
  output logic             devsel_oe_o,
  output logic             trdy_no,
  output logic             trdy_oe_o,
  output logic [AD_W-1:0]  ad_o,
  output logic             ad_oe_o
);
  localparam int PAD_W = AD_W - PIX_W;

  logic             fall, rise, lv_s, accept, trdy;
  logic [PIX_W-1:0] pix_s, pix_q;

  pix2pci_sync #(.STAGES(SYNC_STAGES), .W(PIX_W)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .pclk_i(pclk_i), .lv_i(line_valid_i),
    .pix_i (pix_i), .fall_o(fall), .rise_o(rise), .lv_o(lv_s), .pix_o(pix_s)
  );

  pix2pci_claim u_claim (
    .clk_i (clk_i), .rst_ni(rst_ni), .frame_ni(frame_ni), .irdy_ni(irdy_ni),
    .trdy_i(trdy), .accept_o(accept), .devsel_no(devsel_no), .devsel_oe_o(devsel_oe_o)
  );

  pix2pci_pacer #(.W(PIX_W)) u_pacer (
    .clk_i (clk_i), .rst_ni(rst_ni), .accept_i(accept), .fall_i(fall), .rise_i(rise),
    .lv_i  (lv_s), .pix_i(pix_s), .irdy_ni(irdy_ni), .trdy_o(trdy),
    .ad_oe_o(ad_oe_o), .pix_o(pix_q)
  );

  assign trdy_no   = ~trdy;
  assign trdy_oe_o = devsel_oe_o;

  generate
    if (PAD_W > 0) begin : g_pad
      assign ad_o = {{PAD_W{1'b0}}, pix_q};
    end else begin : g_fit
      assign ad_o = pix_q[AD_W-1:0];
    end
  endgenerate

  a_r8_trdy_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trdy_oe_o && !trdy_no) |-> (ad_oe_o && !devsel_no));
  a_r9_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trdy_oe_o && !trdy_no && !irdy_ni && frame_ni) |=> (devsel_oe_o && devsel_no && trdy_no));
  a_r9_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (devsel_oe_o && devsel_no) |=> (!devsel_oe_o && !trdy_oe_o));
endmodule

// File: tb/pix2pci_target_test.sv
module pix2pci_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 10;
  localparam int AD_W  = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_ni = 1'b1, irdy_ni = 1'b1, pclk_i = 1'b1, line_valid_i = 1'b0;
  logic [PIX_W-1:0] pix_i = '0;
  logic devsel_no, devsel_oe_o, trdy_no, trdy_oe_o, ad_oe_o;
  logic [AD_W-1:0] ad_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix2pci_target uut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_ni(frame_ni), .irdy_ni(irdy_ni),
    .pclk_i(pclk_i), .line_valid_i(line_valid_i), .pix_i(pix_i),
    .devsel_no(devsel_no), .devsel_oe_o(devsel_oe_o), .trdy_no(trdy_no),
    .trdy_oe_o(trdy_oe_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o)
  );

  int n_run = 0, n_fail = 0;
  int seed = 0;
  int beats, target, turn_stage, stall_req, stall_cnt;
  bit stall_started, post_stall, in_txn;
  int exp_data [64];

  task automatic chk(input string tag, input string what, input int act, input int exp_v);
    n_run++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp_v);
    end
  endtask

  function automatic int pixval(input int i);
    return (i * 73 + 19 + seed) % 1024;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0; frame_ni = 1'b1; irdy_ni = 1'b1; pclk_i = 1'b1; line_valid_i = 1'b0;
    in_txn = 0; turn_stage = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // one PCI cycle: bench bus model, then advance to next negedge
  task automatic tick();
    if (turn_stage == 1) begin
      chk("R9", "devsel_oe in turnaround", int'(devsel_oe_o), 1);
      chk("R9", "devsel_no in turnaround", int'(devsel_no), 1);
      chk("R9", "trdy_no in turnaround", int'(trdy_no), 1);
      irdy_ni = 1'b1;
      turn_stage = 2;
    end else if (turn_stage == 2) begin
      chk("R9", "devsel_oe after turnaround", int'(devsel_oe_o), 0);
      chk("R9", "trdy_oe after turnaround", int'(trdy_oe_o), 0);
      turn_stage = 3;
    end
    if (post_stall) begin
      chk("R6", "trdy_no after initiator wait", int'(trdy_no), (stall_req == 2) ? 1 : 0);
      post_stall = 0;
    end
    if (in_txn && turn_stage == 0) begin
      if (!stall_started && stall_req > 0 && trdy_oe_o && !trdy_no) begin
        stall_started = 1;
        stall_cnt = stall_req;
      end
      if (stall_cnt > 0) begin
        irdy_ni = 1'b1;
        stall_cnt--;
        if (stall_cnt == 0) post_stall = 1;
      end else begin
        irdy_ni = 1'b0;
      end
      if (trdy_oe_o && !trdy_no && !irdy_ni) begin
        if (beats == target - 1) frame_ni = 1'b1;
        chk("R8", "ad_oe on beat", int'(ad_oe_o), 1);
        chk("R8", "upper AD bits on beat", int'(ad_o[AD_W-1:PIX_W]), 0);
        if (beats < 64)
          chk("R7", "pixel on beat", int'(ad_o[PIX_W-1:0]), exp_data[beats]);
        beats++;
        if (frame_ni) turn_stage = 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic run_txn(input int ratio, input int npix, input logic [15:0] lvmask,
                         input int stall, input string quiet_tag);
    int e;
    bit drop;
    logic lvb, prevq;
    do_reset();
    seed = seed + 101;
    beats = 0; turn_stage = 0; stall_req = stall; stall_cnt = 0;
    stall_started = 0; post_stall = 0;
    e = 0; drop = (stall == 2);
    for (int i = 0; i < npix; i++) begin
      if (lvmask[i]) begin
        if (drop) drop = 0;
        else begin exp_data[e] = pixval(i); e++; end
      end
    end
    target = e;
    // address phase
    frame_ni = 1'b0; irdy_ni = 1'b1;
    tick();
    chk("R2", "devsel_no after address", int'(devsel_no), 0);
    chk("R2", "devsel_oe after address", int'(devsel_oe_o), 1);
    chk("R2", "ad_oe in first data cycle", int'(ad_oe_o), 0);
    in_txn = 1;
    for (int i = 0; i < npix + 2; i++) begin
      lvb   = (i < npix) ? lvmask[i] : 1'b0;
      prevq = (i == 0) ? 1'b0 : ((i - 1 < npix) ? lvmask[i-1] : 1'b0);
      for (int k = 0; k < ratio; k++) begin
        pclk_i = (k < ratio / 2) ? 1'b0 : 1'b1;
        if (k == 0) begin pix_i = PIX_W'(pixval(i)); line_valid_i = lvb; end
        if (turn_stage == 0 && i < npix) begin
          if (!lvb && !prevq) begin
            chk(quiet_tag, "trdy_no without line valid", int'(trdy_no), 1);
            chk(quiet_tag, "ad_oe without line valid", int'(ad_oe_o), 0);
          end
          if (ratio == 4 && stall == 0 && lvb) begin
            if (k == 1 || k == 2) chk("R4", "trdy_no before third edge", int'(trdy_no), 1);
            if (k == 3) chk("R4", "trdy_no at third edge", int'(trdy_no), 0);
            if (k == 0 && prevq) chk("R5", "trdy_no one cycle per pixel", int'(trdy_no), 1);
          end
        end
        tick();
      end
    end
    chk((ratio == 2) ? "R7" : "R5", "beat count", beats, target);
    chk("R9", "transaction closed", turn_stage, 3);
    in_txn = 0; frame_ni = 1'b1; irdy_ni = 1'b1; line_valid_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    rst_ni = 1'b0; frame_ni = 1'b1; irdy_ni = 1'b1; pclk_i = 1'b1; line_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "devsel_oe in reset", int'(devsel_oe_o), 0);
    chk("R1", "trdy_oe in reset", int'(trdy_oe_o), 0);
    chk("R1", "ad_oe in reset", int'(ad_oe_o), 0);
    chk("R1", "devsel_no in reset", int'(devsel_no), 1);
    chk("R1", "trdy_no in reset", int'(trdy_no), 1);
    rst_ni = 1'b1;
    line_valid_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      pclk_i = ~pclk_i; pix_i = PIX_W'(i * 5);
      @(negedge clk);
    end
    chk("R1", "devsel_oe idle with FRAME# high", int'(devsel_oe_o), 0);
    chk("R1", "ad_oe idle with FRAME# high", int'(ad_oe_o), 0);
    chk("R1", "trdy_oe idle with FRAME# high", int'(trdy_oe_o), 0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    test_reset();
    run_txn(4, 8, 16'h00ff, 0, "R3");          // R2 R4 R5 R8 R9 at 4:1
    run_txn(2, 10, 16'h03ff, 0, "R3");         // R7 at 2:1
    run_txn(4, 9, 16'h01f8, 0, "R3");          // R3 open before line valid
    run_txn(4, 6, 16'h003f, 1, "R3");          // R6 held beat
    run_txn(4, 6, 16'h003f, 2, "R3");          // R6 dropped pixel
    run_txn(4, 9, 16'h01c7, 0, "R10");         // R10 gap inside burst
    finish_run();
  end
endmodule